// File: doc/BRIEF.md
# Ethernet Transmit Retry and Padding Controller

This block sequences one outgoing Ethernet frame at one byte per clock. It tells the byte path whether the current byte comes from the payload or from a pad pattern. It also tracks how many retransmissions remain after collisions. Backoff timing and the frame check sequence are handled elsewhere. Only the byte stream and its attempts are handled here.

A start request latches the payload length and the low byte of a 16-bit pad pattern. The software convention is that both bytes of the pattern are equal. At start, a retry down-counter is loaded from the programmable limit, which is typically 15. Payload bytes are sent first. If the payload is shorter than 60 bytes, pad bytes follow until 60 bytes have gone out. A collision while retries remain costs one retry, and the frame restarts from byte 0 after one idle cycle. A collision with no retries left ends the frame as aborted and raises an interrupt pulse. A one-cycle done flag closes every frame.

Top module: `frame_retry_pad`

## Requirements
- R1: After reset, `tx_active`, `sel_pad`, `done` and `retry_irq` are 0 and `retry_cnt` is 0.
- R2: A `start` seen while idle loads `retry_cnt` with `retry_limit`. The first frame byte is sent in the next cycle, and that cycle shows the loaded count.
- R3: Frame bytes 0 to `pay_len`-1 are sent with `tx_active`=1 and `sel_pad`=0 (0 = payload, 1 = pad).
- R4: If `pay_len` is below 60, bytes `pay_len` to 59 follow with `sel_pad`=1. During these bytes, `pad_byte` equals bits [7:0] of `pad_pattern` as latched at start.
- R5: If `pay_len` is 60 or more, exactly `pay_len` bytes are sent and none of them is a pad byte.
- R6: A collision during a byte while `retry_cnt` is nonzero has three effects. The count drops by 1. The next cycle has `tx_active`=0. The cycle after that sends byte 0 again.
- R7: A collision during a byte while `retry_cnt` is 0 ends the frame in the next cycle. That cycle has `done`=1, `aborted`=1, `retry_irq`=1 and `retry_cnt`=0. `retry_irq` is never high without `done`.
- R8: After the last byte of a collision-free attempt, `done` is 1 for exactly one cycle, with `aborted`=0 and the remaining count on `retry_cnt`. The controller is then idle.
- R9: `start` is ignored while a frame is in progress. The latched length and the latched pad byte do not change.
- R10: A `pay_len` of 0 gives a frame of 60 pad bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame start request, acted on only when idle |
| pay_len | input | LEN_W | Payload length in bytes |
| collision | input | 1 | Collision seen on the current byte |
| retry_limit | input | CNT_W | Retries allowed per frame |
| pad_pattern | input | 16 | Pad pattern; the low byte is sent |
| tx_active | output | 1 | A frame byte is sent this cycle |
| sel_pad | output | 1 | Byte mux select: 0 payload, 1 pad |
| pad_byte | output | 8 | Latched pad byte |
| retry_cnt | output | CNT_W | Retries remaining |
| retry_irq | output | 1 | One-cycle pulse when the retry limit is exhausted |
| done | output | 1 | One-cycle end-of-frame flag |
| aborted | output | 1 | Last frame ended by retry exhaustion |

## Verification
A wrong byte position shows up on the byte stream within one cycle, either as a payload/pad boundary at the wrong place or as a frame that is not 60 bytes long. A wrong retry count shows on `retry_cnt` in the byte cycles that follow the wrong update. It also moves the abort one collision early or late, and that changes the sequence of `done`, `aborted` and `retry_irq`. The bench predicts the complete per-cycle byte sequence of each attempt, so any such change is caught in the cycle where it first appears.

// File: rtl/txrp_pkg.sv
package txrp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEND  = 3'd1,
    ST_PAD   = 3'd2,
    ST_RETRY = 3'd3,
    ST_DONE  = 3'd4
  } txrp_state_e;
endpackage

// File: rtl/txrp_retry_ctr.sv
module txrp_retry_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             is_zero
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)
      count_q <= '0;
    else if (load)
      count_q <= limit;
    else if (dec && count_q != '0)
      count_q <= count_q - 1'b1;
  end

  assign count = count_q;
  assign is_zero = (count_q == '0);

  // R6
  no_count_up_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> (count_q <= $past(count_q)));

  // R7
  no_dec_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    dec |-> (count_q != '0));
endmodule

// File: rtl/txrp_pos.sv
module txrp_pos #(
  parameter int LEN_W     = 11,
  parameter int MIN_BYTES = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] pos,
  output logic             at_last,
  output logic             next_pad
);
  localparam int EXT_W = LEN_W + 1;

  logic [LEN_W-1:0] pos_q;
  logic [EXT_W-1:0] pos_ext, nxt_ext, len_ext, last_ext;

  assign len_ext  = {1'b0, len};
  assign pos_ext  = {1'b0, pos_q};
  assign nxt_ext  = pos_ext + 1'b1;
  assign last_ext = (len_ext < EXT_W'(MIN_BYTES)) ? EXT_W'(MIN_BYTES - 1)
                                                  : len_ext - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clear)
      pos_q <= '0;
    else if (step)
      pos_q <= pos_q + 1'b1;
  end

  assign pos      = pos_q;
  assign at_last  = (pos_ext == last_ext);
  assign next_pad = (nxt_ext >= len_ext);

  // R5
  pos_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> (pos_ext < last_ext));
endmodule

// File: rtl/frame_retry_pad.sv
module frame_retry_pad
  import txrp_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int CNT_W     = 4,
  parameter int MIN_BYTES = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] pay_len,
  input  logic             collision,
  input  logic [CNT_W-1:0] retry_limit,
  input  logic [15:0]      pad_pattern,
  output logic             tx_active,
  output logic             sel_pad,
  output logic [7:0]       pad_byte,
  output logic [CNT_W-1:0] retry_cnt,
  output logic             retry_irq,
  output logic             done,
  output logic             aborted
);
  txrp_state_e      state_q, state_d;
  logic [LEN_W-1:0] len_q;
  logic [7:0]       pad_q;
  logic             aborted_q, irq_q;
  logic             ctr_load, ctr_dec, pos_clear, pos_step, set_abort;
  logic             cnt_zero, at_last, next_pad;
  logic [LEN_W-1:0] pos;
  logic             pad_hi_unused;

  assign pad_hi_unused = ^pad_pattern[15:8];

  txrp_retry_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .load(ctr_load), .dec(ctr_dec),
    .limit(retry_limit), .count(retry_cnt), .is_zero(cnt_zero)
  );

  txrp_pos #(.LEN_W(LEN_W), .MIN_BYTES(MIN_BYTES)) u_pos (
    .clk(clk), .rst(rst), .clear(pos_clear), .step(pos_step),
    .len(len_q), .pos(pos), .at_last(at_last), .next_pad(next_pad)
  );

  always_comb begin
    state_d   = state_q;
    ctr_load  = 1'b0;
    ctr_dec   = 1'b0;
    pos_clear = 1'b0;
    pos_step  = 1'b0;
    set_abort = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        ctr_load  = 1'b1;
        pos_clear = 1'b1;
        state_d   = (pay_len == '0) ? ST_PAD : ST_SEND;
      end
      ST_SEND, ST_PAD: begin
        if (collision) begin
          if (cnt_zero) begin
            set_abort = 1'b1;
            state_d   = ST_DONE;
          end else begin
            ctr_dec = 1'b1;
            state_d = ST_RETRY;
          end
        end else if (at_last) begin
          state_d = ST_DONE;
        end else begin
          pos_step = 1'b1;
          state_d  = next_pad ? ST_PAD : ST_SEND;
        end
      end
      ST_RETRY: begin
        pos_clear = 1'b1;
        state_d   = (len_q == '0) ? ST_PAD : ST_SEND;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      len_q     <= '0;
      pad_q     <= '0;
      aborted_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= set_abort;
      if (state_q == ST_IDLE && start) begin
        len_q     <= pay_len;
        pad_q     <= pad_pattern[7:0];
        aborted_q <= 1'b0;
      end else if (set_abort) begin
        aborted_q <= 1'b1;
      end
    end
  end

  assign tx_active = (state_q == ST_SEND) || (state_q == ST_PAD);
  assign sel_pad   = (state_q == ST_PAD);
  assign done      = (state_q == ST_DONE);
  assign pad_byte  = pad_q;
  assign retry_irq = irq_q;
  assign aborted   = aborted_q;

  // R7
  irq_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    retry_irq |-> (done && aborted && retry_cnt == '0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  retry_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RETRY) |=> (tx_active && pos == '0));

  // R4
  pad_byte_stable_chk: assert property (@(posedge clk) disable iff (rst)
    sel_pad |=> (!sel_pad || $stable(pad_byte)));

  // R9
  busy_len_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(len_q));

  // R3
  payload_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_active && !sel_pad) |-> (pos < len_q));
endmodule

// File: tb/frame_retry_pad_tb.sv
module frame_retry_pad_tb;
  localparam int LEN_W = 11;
  localparam int CNT_W = 4;
  localparam int MINB  = 60;

  logic clk = 0, rst = 1, start = 0, collision = 0;
  logic [LEN_W-1:0] pay_len = '0;
  logic [CNT_W-1:0] retry_limit = '0;
  logic [15:0] pad_pattern = '0;
  logic tx_active, sel_pad, retry_irq, done, aborted;
  logic [7:0] pad_byte;
  logic [CNT_W-1:0] retry_cnt;

  int checks = 0, errors = 0;
  logic [7:0] exp_pad;

  typedef struct {
    bit    is_done;
    bit    sp;
    int    cnt;
    bit    ab;
    string tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  frame_retry_pad #(.LEN_W(LEN_W), .CNT_W(CNT_W), .MIN_BYTES(MINB)) u_dut (
    .clk(clk), .rst(rst), .start(start), .pay_len(pay_len),
    .collision(collision), .retry_limit(retry_limit), .pad_pattern(pad_pattern),
    .tx_active(tx_active), .sel_pad(sel_pad), .pad_byte(pad_byte),
    .retry_cnt(retry_cnt), .retry_irq(retry_irq), .done(done), .aborted(aborted)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as the design produces bytes / done
  always @(negedge clk) begin
    if (!rst) begin
      if (retry_irq && !done) chk(0, "R7 irq without done", 1, 0);
      if (tx_active || done) begin
        if (q.size() == 0) begin
          chk(0, "R8 unexpected output activity", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (!e.is_done) begin
            checks++;
            if (done || sel_pad != e.sp || int'(retry_cnt) != e.cnt ||
                (e.sp && pad_byte != exp_pad)) begin
              errors++;
              $display("FAIL %s byte: done=%0d sel_pad=%0d cnt=%0d pad=%02h expected done=0 sel_pad=%0d cnt=%0d pad=%02h",
                       e.tag, done, sel_pad, retry_cnt, pad_byte, e.sp, e.cnt, exp_pad);
            end
          end else begin
            checks++;
            if (!done || tx_active || aborted != e.ab || retry_irq != e.ab ||
                int'(retry_cnt) != e.cnt) begin
              errors++;
              $display("FAIL %s end: done=%0d active=%0d aborted=%0d irq=%0d cnt=%0d expected done=1 active=0 aborted=%0d irq=%0d cnt=%0d",
                       e.tag, done, tx_active, aborted, retry_irq, retry_cnt, e.ab, e.ab, e.cnt);
            end
          end
        end
      end
    end
  end

  // driver: predicts the byte sequence, then drives the frame
  task automatic run_frame(input int len, input int lim, input logic [15:0] pat,
                           input int ncol, input int cpos, input bit busy, input string tag);
    int total, cnt, nc, bc;
    bit fin, ended;
    exp_t e;
    total = (len < MINB) ? MINB : len;
    cnt = lim; nc = 0; ended = 0;
    while (!ended) begin
      for (int b = 0; b < total; b++) begin
        e.is_done = 0; e.sp = (b >= len); e.cnt = cnt; e.ab = 0;
        e.tag = e.sp ? {tag, " R4"} : {tag, " R3"};
        q.push_back(e);
        if (nc < ncol && b == cpos) begin
          nc++;
          if (cnt == 0) begin
            e.is_done = 1; e.sp = 0; e.cnt = 0; e.ab = 1; e.tag = {tag, " R7"};
            q.push_back(e);
            ended = 1;
          end else begin
            cnt--;
          end
          break;
        end
        if (b == total - 1) begin
          e.is_done = 1; e.sp = 0; e.cnt = cnt; e.ab = 0; e.tag = {tag, " R8"};
          q.push_back(e);
          ended = 1;
        end
      end
    end
    exp_pad = pat[7:0];
    @(negedge clk);
    pay_len = LEN_W'(len); retry_limit = CNT_W'(lim); pad_pattern = pat; start = 1;
    @(negedge clk);
    bc = 0; nc = 0; fin = 0;
    while (!fin) begin
      collision = 0; start = 0; pad_pattern = pat; pay_len = LEN_W'(len);
      if (done) fin = 1;
      else if (tx_active) begin
        if (nc < ncol && bc == cpos) begin collision = 1; nc++; end
        if (busy && bc == 3) begin start = 1; pay_len = 5; pad_pattern = 16'hFFFF; end
        bc++;
      end else bc = 0;
      if (!fin) @(negedge clk);
    end
    collision = 0; start = 0;
    @(negedge clk);
    chk(q.size() == 0, {tag, " R8 frame fully produced"}, q.size(), 0);
    q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!tx_active && !sel_pad, "R1 idle after reset", int'(tx_active), 0);
    chk(!done && !retry_irq, "R1 no done or irq after reset", int'(done), 0);
    chk(retry_cnt == '0, "R1 count after reset", int'(retry_cnt), 0);
    run_frame(10, 15, 16'hA5A5, 0, 0, 0, "short payload R2");
    run_frame(75, 15, 16'h1111, 0, 0, 0, "long payload R5");
    run_frame(60, 7, 16'h2222, 0, 0, 0, "exact minimum R5");
    run_frame(59, 7, 16'h7E7E, 0, 0, 0, "one pad byte R4");
    run_frame(0, 15, 16'h5A5A, 0, 0, 0, "empty payload R10");
    run_frame(20, 3, 16'hC3C3, 2, 5, 0, "two retries R6");
    run_frame(20, 2, 16'h9999, 3, 25, 0, "exhausted in pad R7");
    run_frame(8, 0, 16'h4444, 1, 0, 0, "zero limit R7");
    run_frame(30, 15, 16'h3C3C, 1, 40, 1, "busy start R9");
    run_frame(12, 15, 16'h6666, 0, 0, 0, "after abort R8");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule